// File: doc/BRIEF.md
# Multicycle Five-Step Load/Store Processor Core

This block is a small 32-bit load/store processor that carries each instruction through a sequence of clocked steps. The steps are: fetch, decode with register read, execute or address calculation, memory access or branch completion, and write-back. Each step holds its result in a dedicated register: instruction, next-PC, two operands, immediate, ALU result and loaded data. The step that follows reads only those registers, so no path crosses more than one step.

It decodes three fixed-position instruction formats. Register-register, register-immediate, word load, word store and two zero-compare branches execute. A halt instruction stops the sequencer and raises `done`. The instruction and data memories are internal word arrays. An external agent, normally a test harness, fills them before a run through a debug port while reset is held. After `done` it reads back the data memory and the register file through the same port.

Instruction bits are numbered from the most significant end in the format description: field bit 0 is vector bit 31.

Top module: `mc_risc_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0, returns the sequencer to the fetch step and holds `done` low.
- R2: The opcode is instr[31:26] and the first source is instr[25:21]. For immediate forms instr[20:16] names the destination (or the stored register) and instr[15:0] is an immediate, sign-extended from instr[15]. For register-register forms instr[20:16] is the second source, instr[15:11] the destination and instr[10:0] the function code.
- R3: Opcode 0x00 is register-register. Its function codes are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor and 0x2A signed set-less-than. Any other function code writes 0.
- R4: The immediate opcodes are 0x08 add, 0x0A signed set-less-than, 0x0C and, 0x0D or and 0x0E xor. Each uses the sign-extended immediate.
- R5: Opcode 0x23 loads and 0x2B stores a word at byte address rs1+imm. The low two address bits are ignored, and the word index wraps modulo the memory depth (256 words).
- R6: Opcode 0x04 branches when rs1 is zero and opcode 0x05 when rs1 is non-zero. The target is (PC+4)+imm, with imm in bytes. The PC changes only at the end of the memory step.
- R7: ALU and load instructions take 5 cycles. Stores, branches and undefined opcodes take 4 cycles. Halt (0x3F) takes 2 cycles, after which `done` stays high and the PC and the sequencer are frozen until reset.
- R8: Register 0 reads as zero and ignores writes.
- R9: An undefined opcode changes no register and no memory word, and execution continues at PC+4.
- R10: When `dbg_we` is high, `dbg_wdata` is written at word `dbg_addr`: into instruction memory if `dbg_sel`=0, into data memory if `dbg_sel`=1. `dbg_rdata` shows the same word combinationally. With `dbg_sel`=2 it shows register `dbg_addr[4:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_we | input | 1 | Debug write strobe for the selected memory |
| dbg_sel | input | 2 | Debug target: 0 instruction memory, 1 data memory, 2 register file |
| dbg_addr | input | 8 | Debug word index (register number in the low 5 bits) |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data, combinational |
| done | output | 1 | High once a halt instruction has been decoded |

## Verification
The assertions assume the debug port writes no memory while the core is running, so only the core changes data memory between reset release and `done`. They also assume every program loaded ends in a reachable halt. The stimulus loads all memory contents only while reset is held and ends every program with a halt. It then compares `done` on every clock against the cycle count that a behavioural instruction-level model predicts. It compares registers and data memory only after `done`, once the core has frozen. Registers are compared only after the program has written them, because reset leaves the register file untouched.

// File: rtl/risc_pkg.sv
package risc_pkg;

   localparam int XLEN = 32;
   typedef logic [XLEN-1:0] word_t;

   localparam logic [5:0] OPC_REG   = 6'h00;
   localparam logic [5:0] OPC_BRZ   = 6'h04;
   localparam logic [5:0] OPC_BRNZ  = 6'h05;
   localparam logic [5:0] OPC_ADDI  = 6'h08;
   localparam logic [5:0] OPC_SLTI  = 6'h0A;
   localparam logic [5:0] OPC_ANDI  = 6'h0C;
   localparam logic [5:0] OPC_ORI   = 6'h0D;
   localparam logic [5:0] OPC_XORI  = 6'h0E;
   localparam logic [5:0] OPC_LOAD  = 6'h23;
   localparam logic [5:0] OPC_STORE = 6'h2B;
   localparam logic [5:0] OPC_HALT  = 6'h3F;

   localparam logic [10:0] FN_ADD = 11'h020;
   localparam logic [10:0] FN_SUB = 11'h022;
   localparam logic [10:0] FN_AND = 11'h024;
   localparam logic [10:0] FN_OR  = 11'h025;
   localparam logic [10:0] FN_XOR = 11'h026;
   localparam logic [10:0] FN_SLT = 11'h02A;

   typedef enum logic [2:0] {
      S_FETCH, S_DECODE, S_EXEC, S_MEM, S_WB, S_HALT
   } step_e;

   typedef enum logic [2:0] {
      CL_REG, CL_IMM, CL_LOAD, CL_STORE, CL_BRZ, CL_BRNZ, CL_HALT, CL_NOP
   } iclass_e;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT, ALU_ZERO
   } aluop_e;

   function automatic iclass_e classify(input logic [5:0] opc);
      case (opc)
         OPC_REG:   return CL_REG;
         OPC_ADDI, OPC_SLTI, OPC_ANDI, OPC_ORI, OPC_XORI: return CL_IMM;
         OPC_LOAD:  return CL_LOAD;
         OPC_STORE: return CL_STORE;
         OPC_BRZ:   return CL_BRZ;
         OPC_BRNZ:  return CL_BRNZ;
         OPC_HALT:  return CL_HALT;
         default:   return CL_NOP;
      endcase
   endfunction

   function automatic aluop_e func_op(input logic [10:0] fn);
      case (fn)
         FN_ADD:  return ALU_ADD;
         FN_SUB:  return ALU_SUB;
         FN_AND:  return ALU_AND;
         FN_OR:   return ALU_OR;
         FN_XOR:  return ALU_XOR;
         FN_SLT:  return ALU_SLT;
         default: return ALU_ZERO;
      endcase
   endfunction

   function automatic aluop_e imm_op(input logic [5:0] opc);
      case (opc)
         OPC_SLTI: return ALU_SLT;
         OPC_ANDI: return ALU_AND;
         OPC_ORI:  return ALU_OR;
         OPC_XORI: return ALU_XOR;
         default:  return ALU_ADD;
      endcase
   endfunction

endpackage

// File: rtl/risc_alu.sv
module risc_alu #(
   parameter int W = 32
) (
   input  risc_pkg::aluop_e op,
   input  logic [W-1:0]     lhs,
   input  logic [W-1:0]     rhs,
   output logic [W-1:0]     res
);
   import risc_pkg::*;

   always_comb begin
      unique case (op)
         ALU_ADD:  res = lhs + rhs;
         ALU_SUB:  res = lhs - rhs;
         ALU_AND:  res = lhs & rhs;
         ALU_OR:   res = lhs | rhs;
         ALU_XOR:  res = lhs ^ rhs;
         ALU_SLT:  res = {{(W-1){1'b0}}, ($signed(lhs) < $signed(rhs))};
         default:  res = '0;
      endcase
   end

endmodule

// File: rtl/risc_regfile.sv
module risc_regfile #(
   parameter int NREGS     = 32,
   parameter int W         = 32,
   parameter bit HARD_ZERO = 1'b1,
   localparam int AW       = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] ra1,
   output logic [W-1:0]  rd1,
   input  logic [AW-1:0] ra2,
   output logic [W-1:0]  rd2,
   input  logic [AW-1:0] ra3,
   output logic [W-1:0]  rd3
);

   if ((1 << AW) != NREGS) begin : g_bad_nregs
      $error("risc_regfile: NREGS must be a power of two");
   end

   logic [W-1:0] regs_q [NREGS];

   always_ff @(posedge clk) begin
      if (we && !(HARD_ZERO && (waddr == '0)))
         regs_q[waddr] <= wdata;
   end

   if (HARD_ZERO) begin : g_zero_reg
      assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
      assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
      assign rd3 = (ra3 == '0) ? '0 : regs_q[ra3];
   end else begin : g_plain_reg
      assign rd1 = regs_q[ra1];
      assign rd2 = regs_q[ra2];
      assign rd3 = regs_q[ra3];
   end

endmodule

// File: rtl/risc_wordmem.sv
module risc_wordmem #(
   parameter int WORDS = 256,
   parameter int W     = 32,
   localparam int AW   = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          core_we,
   input  logic [AW-1:0] core_idx,
   input  logic [W-1:0]  core_wdata,
   output logic [W-1:0]  core_rdata,
   input  logic          dbg_we,
   input  logic [AW-1:0] dbg_idx,
   input  logic [W-1:0]  dbg_wdata,
   output logic [W-1:0]  dbg_rdata
);

   if ((1 << AW) != WORDS) begin : g_bad_words
      $error("risc_wordmem: WORDS must be a power of two");
   end

   logic [W-1:0] store_q [WORDS];

   // core port is written last so it wins an index collision
   always_ff @(posedge clk) begin
      if (dbg_we)  store_q[dbg_idx]  <= dbg_wdata;
      if (core_we) store_q[core_idx] <= core_wdata;
   end

   assign core_rdata = store_q[core_idx];
   assign dbg_rdata  = store_q[dbg_idx];

endmodule

// File: rtl/mc_risc_core.sv
module mc_risc_core
   import risc_pkg::*;
#(
   parameter int IMEM_WORDS = 256,
   parameter int DMEM_WORDS = 256,
   parameter int NREGS      = 32,
   localparam int IMEM_AW   = $clog2(IMEM_WORDS),
   localparam int DMEM_AW   = $clog2(DMEM_WORDS),
   localparam int REG_AW    = $clog2(NREGS),
   localparam int DBG_AW    = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dbg_we,
   input  logic [1:0]        dbg_sel,
   input  logic [DBG_AW-1:0] dbg_addr,
   input  logic [XLEN-1:0]   dbg_wdata,
   output logic [XLEN-1:0]   dbg_rdata,
   output logic              done
);

   if (XLEN != 32) begin : g_bad_xlen
      $error("mc_risc_core: instruction formats assume a 32-bit word");
   end
   if (NREGS != 32) begin : g_bad_nregs
      $error("mc_risc_core: register fields are 5 bits wide");
   end
   if (DBG_AW < REG_AW) begin : g_bad_dbg
      $error("mc_risc_core: debug address too narrow for register index");
   end

   localparam logic [1:0] DBG_IMEM = 2'd0;
   localparam logic [1:0] DBG_DMEM = 2'd1;
   localparam logic [1:0] DBG_REGS = 2'd2;

   step_e   step_q;
   word_t   pc_q, npc_q, ir_q, a_q, b_q, imm_q, aluout_q, lmd_q;
   logic    cond_q;

   // fixed-position fields
   logic [5:0]        opc_f;
   logic [REG_AW-1:0] rs1_f, rt_f, rd_f;
   logic [10:0]       fn_f;
   iclass_e           cls;

   assign opc_f = ir_q[31:26];
   assign rs1_f = ir_q[25:21];
   assign rt_f  = ir_q[20:16];
   assign rd_f  = ir_q[15:11];
   assign fn_f  = ir_q[10:0];
   assign cls   = classify(opc_f);

   word_t imem_rdata, imem_dbg_rdata, dmem_rdata, dmem_dbg_rdata;
   word_t rf_rd1, rf_rd2, rf_rd3, rf_wdata, alu_lhs, alu_rhs, alu_res;
   logic [REG_AW-1:0] rf_waddr;
   logic   rf_we, dmem_we, is_branch;
   aluop_e alu_op;

   assign is_branch = (cls == CL_BRZ) || (cls == CL_BRNZ);

   risc_wordmem #(.WORDS(IMEM_WORDS), .W(XLEN)) i_imem (
      .clk        (clk),
      .core_we    (1'b0),
      .core_idx   (pc_q[IMEM_AW+1:2]),
      .core_wdata ('0),
      .core_rdata (imem_rdata),
      .dbg_we     (dbg_we && (dbg_sel == DBG_IMEM)),
      .dbg_idx    (dbg_addr[IMEM_AW-1:0]),
      .dbg_wdata  (dbg_wdata),
      .dbg_rdata  (imem_dbg_rdata)
   );

   assign dmem_we = (step_q == S_MEM) && (cls == CL_STORE);

   risc_wordmem #(.WORDS(DMEM_WORDS), .W(XLEN)) i_dmem (
      .clk        (clk),
      .core_we    (dmem_we),
      .core_idx   (aluout_q[DMEM_AW+1:2]),
      .core_wdata (b_q),
      .core_rdata (dmem_rdata),
      .dbg_we     (dbg_we && (dbg_sel == DBG_DMEM)),
      .dbg_idx    (dbg_addr[DMEM_AW-1:0]),
      .dbg_wdata  (dbg_wdata),
      .dbg_rdata  (dmem_dbg_rdata)
   );

   assign rf_we    = (step_q == S_WB);
   assign rf_waddr = (cls == CL_REG) ? rd_f : rt_f;
   assign rf_wdata = (cls == CL_LOAD) ? lmd_q : aluout_q;

   risc_regfile #(.NREGS(NREGS), .W(XLEN), .HARD_ZERO(1'b1)) i_regs (
      .clk   (clk),
      .we    (rf_we),
      .waddr (rf_waddr),
      .wdata (rf_wdata),
      .ra1   (rs1_f),
      .rd1   (rf_rd1),
      .ra2   (rt_f),
      .rd2   (rf_rd2),
      .ra3   (dbg_addr[REG_AW-1:0]),
      .rd3   (rf_rd3)
   );

   // operand and operation select for the execute step
   always_comb begin
      alu_lhs = a_q;
      alu_rhs = imm_q;
      alu_op  = ALU_ADD;
      unique case (cls)
         CL_REG: begin
            alu_rhs = b_q;
            alu_op  = func_op(fn_f);
         end
         CL_IMM:           alu_op  = imm_op(opc_f);
         CL_BRZ, CL_BRNZ:  alu_lhs = npc_q;
         default: ;
      endcase
   end

   risc_alu #(.W(XLEN)) i_alu (
      .op  (alu_op),
      .lhs (alu_lhs),
      .rhs (alu_rhs),
      .res (alu_res)
   );

   // step sequencer and inter-step registers
   always_ff @(posedge clk) begin
      if (rst) begin
         step_q   <= S_FETCH;
         pc_q     <= '0;
         npc_q    <= '0;
         ir_q     <= '0;
         a_q      <= '0;
         b_q      <= '0;
         imm_q    <= '0;
         aluout_q <= '0;
         lmd_q    <= '0;
         cond_q   <= 1'b0;
      end else begin
         unique case (step_q)
            S_FETCH: begin
               ir_q   <= imem_rdata;
               npc_q  <= pc_q + 32'd4;
               step_q <= S_DECODE;
            end
            S_DECODE: begin
               a_q    <= rf_rd1;
               b_q    <= rf_rd2;
               imm_q  <= {{16{ir_q[15]}}, ir_q[15:0]};
               step_q <= (cls == CL_HALT) ? S_HALT : S_EXEC;
            end
            S_EXEC: begin
               aluout_q <= alu_res;
               cond_q   <= (cls == CL_BRZ) ? (a_q == '0) : (a_q != '0);
               step_q   <= S_MEM;
            end
            S_MEM: begin
               pc_q <= (is_branch && cond_q) ? aluout_q : npc_q;
               if (cls == CL_LOAD) lmd_q <= dmem_rdata;
               step_q <= ((cls == CL_REG) || (cls == CL_IMM) || (cls == CL_LOAD))
                         ? S_WB : S_FETCH;
            end
            S_WB:    step_q <= S_FETCH;
            S_HALT:  step_q <= S_HALT;
            default: step_q <= S_FETCH;
         endcase
      end
   end

   always_comb begin
      unique case (dbg_sel)
         DBG_IMEM: dbg_rdata = imem_dbg_rdata;
         DBG_DMEM: dbg_rdata = dmem_dbg_rdata;
         DBG_REGS: dbg_rdata = rf_rd3;
         default:  dbg_rdata = '0;
      endcase
   end

   assign done = (step_q == S_HALT);

   // R7
   fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
      (step_q == S_FETCH) |=> (step_q == S_DECODE));

   // R7
   halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      (step_q == S_HALT) |=> ((step_q == S_HALT) && $stable(pc_q)));

   // R6
   pc_only_in_mem_chk: assert property (@(posedge clk) disable iff (rst)
      (step_q != S_MEM) |=> $stable(pc_q));

   // R6
   branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
      ((step_q == S_MEM) && is_branch && cond_q) |=> (pc_q == $past(aluout_q)));

   // R8
   zero_reg_read_chk: assert property (@(posedge clk) disable iff (rst)
      ((step_q == S_DECODE) && (rs1_f == '0)) |=> (a_q == '0));

endmodule

// File: tb/test_mc_risc_core.sv
`timescale 1ns/1ps
module test_mc_risc_core;

   logic        clk = 1'b0;
   logic        rst;
   logic        dbg_we;
   logic [1:0]  dbg_sel;
   logic [7:0]  dbg_addr;
   logic [31:0] dbg_wdata;
   logic [31:0] dbg_rdata;
   logic        done;

   always #2.5 clk = ~clk;

   mc_risc_core i_mc_risc_core (
      .clk       (clk),
      .rst       (rst),
      .dbg_we    (dbg_we),
      .dbg_sel   (dbg_sel),
      .dbg_addr  (dbg_addr),
      .dbg_wdata (dbg_wdata),
      .dbg_rdata (dbg_rdata),
      .done      (done)
   );

   localparam logic [5:0] T_REG = 6'h00, T_BZ = 6'h04, T_BNZ = 6'h05,
      T_ADDI = 6'h08, T_SLTI = 6'h0A, T_ANDI = 6'h0C, T_ORI = 6'h0D,
      T_XORI = 6'h0E, T_LW = 6'h23, T_SW = 6'h2B, T_HALT = 6'h3F;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   logic [31:0] prog[$];
   logic [31:0] m_imem [256];
   logic [31:0] m_dmem [256];
   logic [31:0] m_regs [32];
   bit          m_wr   [32];
   int          exp_total;

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
      return {T_REG, rs[4:0], rt[4:0], rd[4:0], fn[10:0]};
   endfunction

   function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
      return {op, rs[4:0], rt[4:0], imm[15:0]};
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   // instruction-level reference model, also sums expected cycles
   task automatic model_write(int r, logic [31:0] v);
      m_wr[r] = 1'b1;
      if (r != 0) m_regs[r] = v;
   endtask

   task automatic run_model();
      logic [31:0] pc = 0;
      int n = 0;
      exp_total = 0;
      for (int i = 0; i < 32; i++) begin m_regs[i] = 0; m_wr[i] = 1'b0; end
      while (n < 5000) begin
         logic [31:0] ir = m_imem[pc[9:2]];
         logic [5:0]  op = ir[31:26];
         int rs = ir[25:21], rt = ir[20:16], rd = ir[15:11];
         logic [10:0] fn = ir[10:0];
         logic [31:0] imm = {{16{ir[15]}}, ir[15:0]};
         logic [31:0] a = m_regs[rs], b = m_regs[rt], npc = pc + 4, ea, v;
         n++;
         if (op == T_HALT) begin exp_total += 2; break; end
         case (op)
            T_REG: begin
               case (fn)
                  11'h020: v = a + b;
                  11'h022: v = a - b;
                  11'h024: v = a & b;
                  11'h025: v = a | b;
                  11'h026: v = a ^ b;
                  11'h02A: v = ($signed(a) < $signed(b)) ? 1 : 0;
                  default: v = 0;
               endcase
               model_write(rd, v); exp_total += 5; pc = npc;
            end
            T_ADDI, T_SLTI, T_ANDI, T_ORI, T_XORI: begin
               case (op)
                  T_ADDI:  v = a + imm;
                  T_SLTI:  v = ($signed(a) < $signed(imm)) ? 1 : 0;
                  T_ANDI:  v = a & imm;
                  T_ORI:   v = a | imm;
                  default: v = a ^ imm;
               endcase
               model_write(rt, v); exp_total += 5; pc = npc;
            end
            T_LW: begin
               ea = a + imm; model_write(rt, m_dmem[ea[9:2]]);
               exp_total += 5; pc = npc;
            end
            T_SW: begin
               ea = a + imm; m_dmem[ea[9:2]] = b; exp_total += 4; pc = npc;
            end
            T_BZ:  begin exp_total += 4; pc = (a == 0) ? npc + imm : npc; end
            T_BNZ: begin exp_total += 4; pc = (a != 0) ? npc + imm : npc; end
            default: begin exp_total += 4; pc = npc; end
         endcase
      end
   endtask

   task automatic dbg_write(logic [1:0] sel, int idx, logic [31:0] data);
      @(negedge clk);
      dbg_sel = sel; dbg_addr = idx[7:0]; dbg_wdata = data; dbg_we = 1'b1;
      @(negedge clk);
      dbg_we = 1'b0;
   endtask

   task automatic dbg_read(logic [1:0] sel, int idx, output logic [31:0] data);
      @(negedge clk);
      dbg_sel = sel; dbg_addr = idx[7:0];
      #1 data = dbg_rdata;
   endtask

   task automatic run_test(string reg_req, logic [31:0] seed);
      int edges = 0;
      logic [31:0] rd;
      rst = 1'b1;
      for (int i = 0; i < 256; i++)
         m_imem[i] = (i < prog.size()) ? prog[i] : {T_HALT, 26'd0};
      for (int i = 0; i < prog.size(); i++) dbg_write(2'd0, i, prog[i]);
      for (int i = 0; i < 256; i++) begin
         m_dmem[i] = 32'hA500_0000 ^ (i * 32'h0101_0101) ^ seed;
         dbg_write(2'd1, i, m_dmem[i]);
      end
      @(negedge clk);
      chk("R1", "done during reset", {31'd0, done}, 32'd0);
      dbg_read(2'd0, 0, rd);
      chk("R10", "imem readback", rd, prog[0]);
      run_model();
      @(negedge clk);
      rst = 1'b0;
      while (edges < exp_total + 6) begin
         @(negedge clk);
         edges++;
         chk("R7", "done timing", {31'd0, done}, {31'd0, (edges >= exp_total)});
      end
      for (int r = 0; r < 32; r++) begin
         if (r == 0) begin
            dbg_read(2'd2, 0, rd);
            chk("R8", "r0 value", rd, 32'd0);
         end else if (m_wr[r]) begin
            dbg_read(2'd2, r, rd);
            chk(reg_req, $sformatf("r%0d", r), rd, m_regs[r]);
         end
      end
      for (int i = 0; i < 256; i++) begin
         dbg_read(2'd1, i, rd);
         chk("R5", $sformatf("dmem[%0d]", i), rd, m_dmem[i]);
      end
   endtask

   initial begin
      rst = 1'b1; dbg_we = 1'b0; dbg_sel = 2'd0; dbg_addr = '0; dbg_wdata = '0;
      repeat (3) @(negedge clk);

      // R2 R3: register-register functions, rd field versus rt field
      prog = {};
      prog.push_back(enc_i(T_ADDI, 0, 1, 16'h1234));
      prog.push_back(enc_i(T_ADDI, 0, 2, -5));
      prog.push_back(enc_r(1, 2, 3, 11'h020));
      prog.push_back(enc_r(2, 1, 4, 11'h022));
      prog.push_back(enc_r(1, 2, 5, 11'h024));
      prog.push_back(enc_r(1, 2, 6, 11'h025));
      prog.push_back(enc_r(1, 2, 7, 11'h026));
      prog.push_back(enc_r(2, 1, 8, 11'h02A));
      prog.push_back(enc_r(1, 2, 9, 11'h02A));
      prog.push_back(enc_r(1, 1, 0, 11'h020));
      prog.push_back(enc_r(0, 1, 10, 11'h020));
      prog.push_back(enc_r(1, 2, 11, 11'h031));
      prog.push_back({T_HALT, 26'd0});
      run_test("R2 R3", 32'h0000_0011);

      // R4: immediates, sign extension of negative values
      prog = {};
      prog.push_back(enc_i(T_ADDI, 0, 1, -1));
      prog.push_back(enc_i(T_ANDI, 1, 2, 16'h8000));
      prog.push_back(enc_i(T_ORI,  0, 3, 16'h7FFF));
      prog.push_back(enc_i(T_XORI, 1, 4, 16'h00F0));
      prog.push_back(enc_i(T_SLTI, 0, 5, -3));
      prog.push_back(enc_i(T_SLTI, 1, 6, 1));
      prog.push_back(enc_i(T_ADDI, 3, 7, -32768));
      prog.push_back({T_HALT, 26'd0});
      run_test("R4", 32'h0000_2200);

      // R5: word load/store, ignored low bits, index wrap
      prog = {};
      prog.push_back(enc_i(T_ADDI, 0, 1, 16'h0040));
      prog.push_back(enc_i(T_LW, 1, 2, 8));
      prog.push_back(enc_i(T_LW, 1, 3, -2));
      prog.push_back(enc_i(T_SW, 1, 2, 3));
      prog.push_back(enc_i(T_LW, 0, 4, 16'h0043));
      prog.push_back(enc_i(T_ADDI, 0, 5, 16'h03FC));
      prog.push_back(enc_i(T_LW, 5, 6, 8));
      prog.push_back(enc_i(T_SW, 5, 3, 4));
      prog.push_back(enc_i(T_LW, 0, 7, 0));
      prog.push_back({T_HALT, 26'd0});
      run_test("R5", 32'h0033_0000);

      // R6: countdown loop with backward branch, taken and not-taken forms
      prog = {};
      prog.push_back(enc_i(T_ADDI, 0, 1, 5));
      prog.push_back(enc_i(T_ADDI, 0, 2, 0));
      prog.push_back(enc_i(T_ADDI, 2, 2, 3));
      prog.push_back(enc_i(T_ADDI, 1, 1, -1));
      prog.push_back(enc_i(T_BNZ, 1, 0, -12));
      prog.push_back(enc_i(T_BZ, 1, 0, 4));
      prog.push_back(enc_i(T_ADDI, 0, 3, 99));
      prog.push_back(enc_i(T_BZ, 2, 0, 4));
      prog.push_back(enc_i(T_ADDI, 0, 4, 7));
      prog.push_back(enc_i(T_BNZ, 0, 0, 4));
      prog.push_back(enc_i(T_ADDI, 0, 5, 8));
      prog.push_back({T_HALT, 26'd0});
      run_test("R6", 32'h4400_0000);

      // R9: undefined opcodes behave as no-ops
      prog = {};
      prog.push_back(enc_i(T_ADDI, 0, 1, 1));
      prog.push_back({6'h15, 5'd1, 5'd1, 16'hFFFF});
      prog.push_back(enc_i(T_ADDI, 1, 2, 1));
      prog.push_back({6'h3E, 5'd2, 5'd3, 16'h0010});
      prog.push_back(enc_i(T_ADDI, 2, 3, 1));
      prog.push_back({T_HALT, 26'd0});
      run_test("R9", 32'h0000_0055);

      // R7: halt as the first instruction
      prog = {};
      prog.push_back({T_HALT, 26'd0});
      run_test("R7", 32'h6600_0000);

      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule